// File: doc/BRIEF.md
# Debug Scan Port with Instruction and Data Transfer Chains

This block is the debug test access port of a processor core. A host drives the four-wire serial test interface (clock, mode select, data in, data out) through the standard sixteen-state controller. A 5-bit instruction register decides what sits between data in and data out. That is either a 1-bit bypass cell, a 5-bit chain-select register, a 33-bit instruction-transfer chain or a 34-bit data-transfer chain. The chain-select register is written indirectly. The host loads it under the select instruction, and the chosen chain is then reached under the two test instructions. A dedicated shortcut instruction reaches the instruction-transfer chain directly and leaves the select register untouched.

On the core side the block presents a one-cycle issue strobe with a latched opcode, and it takes back a completion pulse. It also holds a host-to-core word with a valid flag, which the core empties with an acknowledge. For the other direction it samples a core-to-host word with a full flag and pulses an acknowledge when the host has taken it. An opcode is issued each time the controller newly enters Run-Test/Idle while an issuing configuration is active. Staying in Run-Test/Idle does not issue again. The design runs entirely on the test clock, and its test reset is synchronous and active high.

Top module: `dbg_tap_top`

## Requirements
- R1: While `rst` is high, or after five test-clock cycles with `tms` high from any state, the controller is in Test-Logic-Reset. The instruction register then holds the bypass code 5'h1F and the chain select holds 0, so a data scan passes through a 1-bit cell.
- R2: The instruction register is 5 bits, shifted LSB first, and captures 5'b00001. The codes are: EXTEST 5'h00, SCAN_N 5'h02, INTEST 5'h0C, ITRSEL 5'h1D and BYPASS 5'h1F. Any other code selects the 1-bit bypass cell, which captures 0.
- R3: Under SCAN_N the data path is the 5-bit chain-select register. It captures 5'h10, and the shifted value becomes the chain select only at Update-DR.
- R4: The instruction chain is 33 bits, shifted LSB first. Bits 0..31 are the opcode and capture as 0. Bit 32 captures the completion flag, which is 1 after reset, falls when an opcode is issued and rises on `issue_done`. The opcode is latched at Update-DR.
- R5: ITRSEL routes the data path to the 33-bit instruction chain and leaves the chain select unchanged. A later INTEST again reaches the chain selected before.
- R6: Entering Run-Test/Idle from another state raises `issue_valid` for one cycle, carrying the latched opcode. This happens when the IR holds ITRSEL, or when it holds INTEST or EXTEST with chain 4 (instruction) or chain 5 (data) selected.
- R7: Remaining in Run-Test/Idle for further cycles issues nothing more.
- R8: The data chain is 34 bits: bits 0..31 data, bit 32 Ready, bit 33 nRetry (captured as 1). Under EXTEST, Ready captures as the inverse of `h2c_valid` and the data bits capture 0. When Ready was 1, Update-DR loads `h2c_data` and sets `h2c_valid`.
- R9: Under EXTEST, a word shifted while Ready captured 0 is discarded, and `h2c_data` keeps its value.
- R10: Under INTEST, the data bits capture `c2h_data` and Ready captures `c2h_full`. When Ready was 1, Update-DR pulses `c2h_ack` for one cycle. Otherwise there is no acknowledge.
- R11: Under INTEST or EXTEST with a chain select other than 4 or 5 (chain 0, for example), the data path is the 1-bit bypass cell and entering Run-Test/Idle issues nothing.
- R12: `h2c_ack` clears `h2c_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the active shift register in a shift state, else 0 |
| issue_valid | output | 1 | One-cycle strobe: execute `issue_opcode` |
| issue_opcode | output | 32 | Latched opcode |
| issue_done | input | 1 | Core pulse: issued opcode completed |
| h2c_data | output | 32 | Word from host to core |
| h2c_valid | output | 1 | `h2c_data` holds an unread word |
| h2c_ack | input | 1 | Core has consumed `h2c_data` |
| c2h_data | input | 32 | Word from core to host |
| c2h_full | input | 1 | `c2h_data` holds a word for the host |
| c2h_ack | output | 1 | One-cycle pulse: host has taken `c2h_data` |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, chain 4 for instructions and chain 5 for data. With these values the three scan lengths are 1, 33 and 34. A single 64-bit probe scan therefore measures which chain is routed, without reading any internal signal. Random opcodes and data words cover the issue, host-to-core and core-to-host paths. Directed cases cover the points where behaviour turns:
- a completion flag read while an opcode is outstanding;
- dwelling in Run-Test/Idle;
- a host-to-core slot that is still full;
- an empty core-to-host slot;
- chain 0 disabling issue;
- the mode-select reset.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

    localparam int IR_W  = 5;
    localparam int SEL_W = 5;

    localparam logic [IR_W-1:0]  IR_EXTEST  = 5'h00;
    localparam logic [IR_W-1:0]  IR_SCAN_N  = 5'h02;
    localparam logic [IR_W-1:0]  IR_INTEST  = 5'h0C;
    localparam logic [IR_W-1:0]  IR_ITRSEL  = 5'h1D;
    localparam logic [IR_W-1:0]  IR_BYPASS  = 5'h1F;
    localparam logic [IR_W-1:0]  IR_CAPTURE = 5'b00001;
    localparam logic [SEL_W-1:0] SEL_CAPTURE = 5'h10;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS, PATH_SELECT, PATH_ITR, PATH_DTR
    } path_e;

    typedef struct packed {
        path_e path;
        logic  issue_en;
        logic  is_intest;
    } route_t;

    function automatic tap_state_e tap_next(tap_state_e st, logic tms);
        tap_state_e nx;
        case (st)
            ST_RESET:    nx = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nx = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   nx = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   nx = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_SHIFT: nx = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_EX1:   nx = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nx = tms ? ST_DR_EX2   : ST_DR_PAUSE;
            ST_DR_EX2:   nx = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nx = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   nx = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nx = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_SHIFT: nx = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_EX1:   nx = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nx = tms ? ST_IR_EX2   : ST_IR_PAUSE;
            ST_IR_EX2:   nx = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            default:     nx = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
        return nx;
    endfunction

    function automatic route_t route_decode(logic [IR_W-1:0] ir, logic [SEL_W-1:0] sel,
                                            logic [SEL_W-1:0] itr_id, logic [SEL_W-1:0] dtr_id);
        route_t r;
        r.path      = PATH_BYPASS;
        r.issue_en  = 1'b0;
        r.is_intest = (ir == IR_INTEST);
        case (ir)
            IR_SCAN_N: r.path = PATH_SELECT;
            IR_ITRSEL: begin
                r.path     = PATH_ITR;
                r.issue_en = 1'b1;
            end
            IR_INTEST, IR_EXTEST: begin
                if (sel == itr_id) begin
                    r.path     = PATH_ITR;
                    r.issue_en = 1'b1;
                end else if (sel == dtr_id) begin
                    r.path     = PATH_DTR;
                    r.issue_en = 1'b1;
                end
            end
            default: r.path = PATH_BYPASS;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output logic       entered_idle
);
    tap_state_e prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET;
            prev  <= ST_RESET;
        end else begin
            state <= tap_next(state, tms);
            prev  <= state;
        end
    end

    assign entered_idle = (state == ST_IDLE) && (prev != ST_IDLE);
endmodule

// File: rtl/dbg_tap_ctl.sv
module dbg_tap_ctl
    import dbg_tap_pkg::*;
#(
    parameter int ITR_CHAIN = 4,
    parameter int DTR_CHAIN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_state_e        state,
    input  logic              tdi,
    output logic [IR_W-1:0]   ir,
    output logic [SEL_W-1:0]  chain_sel,
    output route_t            route,
    output logic              tdo_ir,
    output logic              tdo_sel
);
    localparam logic [SEL_W-1:0] ITR_ID = SEL_W'(ITR_CHAIN);
    localparam logic [SEL_W-1:0] DTR_ID = SEL_W'(DTR_CHAIN);

    logic [IR_W-1:0]  ir_sr;
    logic [SEL_W-1:0] sel_sr;
    logic             sel_active;

    assign route      = route_decode(ir, chain_sel, ITR_ID, DTR_ID);
    assign sel_active = (route.path == PATH_SELECT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir    <= IR_BYPASS;
            ir_sr <= '0;
        end else begin
            case (state)
                ST_RESET:    ir    <= IR_BYPASS;
                ST_IR_CAP:   ir_sr <= IR_CAPTURE;
                ST_IR_SHIFT: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_IR_UPD:   ir    <= ir_sr;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_sel <= '0;
            sel_sr    <= '0;
        end else if (state == ST_RESET) begin
            chain_sel <= '0;
        end else if (sel_active) begin
            case (state)
                ST_DR_CAP:   sel_sr    <= SEL_CAPTURE;
                ST_DR_SHIFT: sel_sr    <= {tdi, sel_sr[SEL_W-1:1]};
                ST_DR_UPD:   chain_sel <= sel_sr;
                default:     ;
            endcase
        end
    end

    assign tdo_ir  = ir_sr[0];
    assign tdo_sel = sel_sr[0];
endmodule

// File: rtl/dbg_tap_itr.sv
module dbg_tap_itr
    import dbg_tap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_state_e        state,
    input  logic              active,
    input  logic              issue_en,
    input  logic              entered_idle,
    input  logic              tdi,
    input  logic              issue_done,
    output logic              tdo,
    output logic              issue_valid,
    output logic [DATA_W-1:0] issue_opcode
);
    localparam int ITR_LEN = DATA_W + 1;

    logic [ITR_LEN-1:0] sr;
    logic [DATA_W-1:0]  opcode;
    logic               done_flag;

    assign issue_valid  = entered_idle && issue_en;
    assign issue_opcode = opcode;
    assign tdo          = sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            opcode <= '0;
        end else if (active) begin
            case (state)
                ST_DR_CAP:   sr     <= {done_flag, {DATA_W{1'b0}}};
                ST_DR_SHIFT: sr     <= {tdi, sr[ITR_LEN-1:1]};
                ST_DR_UPD:   opcode <= sr[DATA_W-1:0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              done_flag <= 1'b1;
        else if (issue_valid) done_flag <= 1'b0;
        else if (issue_done)  done_flag <= 1'b1;
    end
endmodule

// File: rtl/dbg_tap_dtr.sv
module dbg_tap_dtr
    import dbg_tap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_state_e        state,
    input  logic              active,
    input  logic              is_intest,
    input  logic              tdi,
    input  logic              h2c_ack,
    input  logic [DATA_W-1:0] c2h_data,
    input  logic              c2h_full,
    output logic              tdo,
    output logic [DATA_W-1:0] h2c_data,
    output logic              h2c_valid,
    output logic              c2h_ack
);
    localparam int DTR_LEN = DATA_W + 2;

    logic [DTR_LEN-1:0] sr;
    logic               rdy_cap;
    logic               do_update;

    assign tdo       = sr[0];
    assign do_update = active && (state == ST_DR_UPD) && rdy_cap;
    assign c2h_ack   = do_update && is_intest;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            rdy_cap <= 1'b0;
        end else if (active) begin
            case (state)
                ST_DR_CAP: begin
                    if (is_intest) begin
                        sr      <= {1'b1, c2h_full, c2h_data};
                        rdy_cap <= c2h_full;
                    end else begin
                        sr      <= {1'b1, ~h2c_valid, {DATA_W{1'b0}}};
                        rdy_cap <= ~h2c_valid;
                    end
                end
                ST_DR_SHIFT: sr <= {tdi, sr[DTR_LEN-1:1]};
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h2c_data  <= '0;
            h2c_valid <= 1'b0;
        end else if (do_update && !is_intest) begin
            h2c_data  <= sr[DATA_W-1:0];
            h2c_valid <= 1'b1;
        end else if (h2c_ack) begin
            h2c_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_tap_top.sv
module dbg_tap_top
    import dbg_tap_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ITR_CHAIN = 4,
    parameter int DTR_CHAIN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              issue_valid,
    output logic [DATA_W-1:0] issue_opcode,
    input  logic              issue_done,
    output logic [DATA_W-1:0] h2c_data,
    output logic              h2c_valid,
    input  logic              h2c_ack,
    input  logic [DATA_W-1:0] c2h_data,
    input  logic              c2h_full,
    output logic              c2h_ack
);
    tap_state_e       state;
    logic             entered_idle;
    logic [IR_W-1:0]  ir;
    logic [SEL_W-1:0] chain_sel;
    route_t           route;
    logic             tdo_ir, tdo_sel, tdo_itr, tdo_dtr;
    logic             byp;

    dbg_tap_fsm u_fsm (
        .clk(clk), .rst(rst), .tms(tms),
        .state(state), .entered_idle(entered_idle)
    );

    dbg_tap_ctl #(.ITR_CHAIN(ITR_CHAIN), .DTR_CHAIN(DTR_CHAIN)) u_ctl (
        .clk(clk), .rst(rst), .state(state), .tdi(tdi),
        .ir(ir), .chain_sel(chain_sel), .route(route),
        .tdo_ir(tdo_ir), .tdo_sel(tdo_sel)
    );

    dbg_tap_itr #(.DATA_W(DATA_W)) u_itr (
        .clk(clk), .rst(rst), .state(state),
        .active(route.path == PATH_ITR), .issue_en(route.issue_en),
        .entered_idle(entered_idle), .tdi(tdi), .issue_done(issue_done),
        .tdo(tdo_itr), .issue_valid(issue_valid), .issue_opcode(issue_opcode)
    );

    dbg_tap_dtr #(.DATA_W(DATA_W)) u_dtr (
        .clk(clk), .rst(rst), .state(state),
        .active(route.path == PATH_DTR), .is_intest(route.is_intest),
        .tdi(tdi), .h2c_ack(h2c_ack), .c2h_data(c2h_data), .c2h_full(c2h_full),
        .tdo(tdo_dtr), .h2c_data(h2c_data), .h2c_valid(h2c_valid), .c2h_ack(c2h_ack)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byp <= 1'b0;
        end else if (route.path == PATH_BYPASS) begin
            if (state == ST_DR_CAP)        byp <= 1'b0;
            else if (state == ST_DR_SHIFT) byp <= tdi;
        end
    end

    always_comb begin
        tdo = 1'b0;
        if (state == ST_IR_SHIFT) begin
            tdo = tdo_ir;
        end else if (state == ST_DR_SHIFT) begin
            case (route.path)
                PATH_SELECT: tdo = tdo_sel;
                PATH_ITR:    tdo = tdo_itr;
                PATH_DTR:    tdo = tdo_dtr;
                default:     tdo = byp;
            endcase
        end
    end
endmodule

// File: rtl/dbg_tap_chk.sv
module dbg_tap_chk
    import dbg_tap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir,
    input logic [SEL_W-1:0]  chain_sel,
    input logic              issue_valid,
    input logic [DATA_W-1:0] h2c_data,
    input logic              h2c_valid,
    input logic              h2c_ack,
    input logic              c2h_ack
);
    // R1: leaving Test-Logic-Reset leaves bypass IR and chain 0
    p_tlr_default_r1: assert property (@(posedge clk) disable iff (rst)
        state == ST_RESET |=> ir == IR_BYPASS && chain_sel == '0);

    // R3: chain select changes only at Update-DR or in Test-Logic-Reset
    p_sel_update_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(chain_sel) |-> $past(state) == ST_DR_UPD || $past(state) == ST_RESET);

    // R6: issue only in the first Run-Test/Idle cycle
    p_issue_entry_r6: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> state == ST_IDLE && $past(state) != ST_IDLE);

    // R7: never two issue cycles in a row
    p_issue_single_r7: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !issue_valid);

    // R8: the host word appears only out of Update-DR
    p_h2c_load_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(h2c_valid) |-> $past(state) == ST_DR_UPD);

    // R9: a pending host word is never overwritten
    p_h2c_hold_r9: assert property (@(posedge clk) disable iff (rst)
        h2c_valid && !h2c_ack |=> h2c_valid && $stable(h2c_data));

    // R10: the core-to-host acknowledge is a single pulse
    p_c2h_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        c2h_ack |=> !c2h_ack);

    // R12: acknowledge empties the host-to-core slot
    p_h2c_clear_r12: assert property (@(posedge clk) disable iff (rst)
        h2c_valid && h2c_ack |=> !h2c_valid);
endmodule

bind dbg_tap_top dbg_tap_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .state(state), .ir(ir), .chain_sel(chain_sel),
    .issue_valid(issue_valid), .h2c_data(h2c_data), .h2c_valid(h2c_valid),
    .h2c_ack(h2c_ack), .c2h_ack(c2h_ack)
);

// File: tb/dbg_tap_top_tb.sv
`timescale 1ns/1ps
module dbg_tap_top_tb;
    localparam int DW = 32;
    localparam logic [4:0] C_EXTEST = 5'h00, C_SCANN = 5'h02, C_INTEST = 5'h0C,
                           C_ITRSEL = 5'h1D, C_BYPASS = 5'h1F;
    localparam logic [63:0] PROBE = 64'h9E37_79B9_7F4A_7C15;

    logic clk = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic tdo, issue_valid, issue_done = 1'b0, h2c_valid, h2c_ack = 1'b0;
    logic c2h_full = 1'b0, c2h_ack;
    logic [DW-1:0] issue_opcode, h2c_data, c2h_data = '0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    bit at_sel = 0;

    // core stand-in state
    int done_lat = 2, cd = 0, issue_cnt = 0, h2c_taken = 0, c2h_taken = 0;
    logic [DW-1:0] last_op = '0, h2c_last = '0;
    bit h2c_auto = 0;

    always #4 clk = ~clk;

    dbg_tap_top #(.DATA_W(DW), .ITR_CHAIN(4), .DTR_CHAIN(5)) u_dut (
        .clk(clk), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .issue_valid(issue_valid), .issue_opcode(issue_opcode), .issue_done(issue_done),
        .h2c_data(h2c_data), .h2c_valid(h2c_valid), .h2c_ack(h2c_ack),
        .c2h_data(c2h_data), .c2h_full(c2h_full), .c2h_ack(c2h_ack)
    );

    always @(negedge clk) begin
        issue_done = 1'b0;
        h2c_ack    = 1'b0;
        if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) issue_done = 1'b1;
        end
        if (!rst && issue_valid) begin
            issue_cnt = issue_cnt + 1;
            last_op   = issue_opcode;
            cd        = done_lat;
        end
        if (!rst && h2c_valid && h2c_auto) begin
            h2c_ack   = 1'b1;
            h2c_last  = h2c_data;
            h2c_taken = h2c_taken + 1;
        end
        if (!rst && c2h_ack) begin
            c2h_taken = c2h_taken + 1;
            c2h_full  = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tck(input logic m, input logic d, output logic o);
        @(negedge clk);
        tms = m;
        tdi = d;
        #1 o = tdo;
        @(posedge clk);
    endtask

    task automatic to_sel();
        logic o;
        if (!at_sel) tck(1'b1, 1'b0, o);
        at_sel = 1;
    endtask

    task automatic finish_scan(input bit end_idle);
        logic o;
        tck(1'b1, 1'b0, o);
        if (end_idle) begin
            tck(1'b0, 1'b0, o);
            at_sel = 0;
        end else begin
            tck(1'b1, 1'b0, o);
            at_sel = 1;
        end
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout, input bit end_idle);
        logic o;
        dout = '0;
        to_sel();
        tck(1'b0, 1'b0, o);
        tck(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            tck(i == n - 1, din[i], o);
            dout[i] = o;
        end
        finish_scan(end_idle);
    endtask

    task automatic scan_ir(input logic [4:0] code, output logic [4:0] cap, input bit end_idle);
        logic o;
        to_sel();
        tck(1'b1, 1'b0, o);
        tck(1'b0, 1'b0, o);
        tck(1'b0, 1'b0, o);
        for (int i = 0; i < 5; i++) begin
            tck(i == 4, code[i], o);
            cap[i] = o;
        end
        finish_scan(end_idle);
    endtask

    task automatic idle_wait(input int n);
        logic o;
        for (int i = 0; i < n; i++) tck(1'b0, 1'b0, o);
    endtask

    function automatic int chain_len(input logic [63:0] din, input logic [63:0] dout);
        for (int l = 1; l < 60; l++)
            if ((dout >> l) == (din & ((64'd1 << (64 - l)) - 64'd1))) return l;
        return 0;
    endfunction

    task automatic probe(output int len, output logic [63:0] dout);
        scan_dr(64, PROBE, dout, 1'b0);
        len = chain_len(PROBE, dout);
    endtask

    task automatic set_chain(input logic [4:0] ch);
        logic [4:0] c;
        logic [63:0] d;
        scan_ir(C_SCANN, c, 1'b0);
        scan_dr(5, 64'(ch), d, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] cap;
        logic [63:0] d;
        logic o;
        int len, c0, t0;
        logic [DW-1:0] op, w, w2;
        void'($urandom(32'h5EED_1234));

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        tck(1'b0, 1'b0, o);
        at_sel = 0;

        // R1: after reset the data path is the 1-bit bypass cell
        probe(len, d);
        chk("R1", "reset dr length", 64'(len), 64'd1);
        chk("R1", "reset h2c_valid", 64'(h2c_valid), 64'd0);
        // R2: IR capture pattern
        scan_ir(C_BYPASS, cap, 1'b0);
        chk("R2", "ir capture", 64'(cap), 64'h01);
        // R2: unlisted code routes to bypass
        scan_ir(5'h07, cap, 1'b0);
        probe(len, d);
        chk("R2", "unknown code length", 64'(len), 64'd1);
        chk("R2", "bypass capture bit", 64'(d[0]), 64'd0);

        // R3: select register capture and effect
        scan_ir(C_SCANN, cap, 1'b0);
        scan_dr(5, 64'd5, d, 1'b0);
        chk("R3", "select capture", d & 64'h1F, 64'h10);
        scan_ir(C_INTEST, cap, 1'b0);
        probe(len, d);
        chk("R3", "chain 5 length", 64'(len), 64'd34);

        // R5: shortcut to instruction chain leaves select alone
        scan_ir(C_ITRSEL, cap, 1'b0);
        probe(len, d);
        chk("R5", "itrsel length", 64'(len), 64'd33);
        chk("R4", "reset completion flag", 64'(d[32]), 64'd1);
        chk("R4", "opcode capture zero", d & 64'hFFFF_FFFF, 64'd0);
        scan_ir(C_INTEST, cap, 1'b0);
        probe(len, d);
        chk("R5", "select kept after itrsel", 64'(len), 64'd34);

        // R4 R6 R7: issue, flag low while outstanding, dwell
        scan_ir(C_ITRSEL, cap, 1'b0);
        done_lat = 30;
        op = 32'hE1A0_0000;
        c0 = issue_cnt;
        scan_dr(33, 64'(op), d, 1'b1);
        scan_dr(33, 64'(op), d, 1'b1);
        chk("R4", "flag low while outstanding", 64'(d[32]), 64'd0);
        idle_wait(40);
        chk("R7", "dwell issues nothing more", 64'(issue_cnt - c0), 64'd2);
        chk("R6", "issued opcode", 64'(last_op), 64'(op));
        scan_dr(33, 64'(op), d, 1'b0);
        chk("R4", "flag high after done", 64'(d[32]), 64'd1);

        // R6: random opcodes
        done_lat = 2;
        for (int k = 0; k < 24; k++) begin
            op = $urandom;
            c0 = issue_cnt;
            scan_dr(33, 64'(op), d, 1'b1);
            idle_wait(2);
            chk("R6", "random issue count", 64'(issue_cnt - c0), 64'd1);
            chk("R6", "random opcode", 64'(last_op), 64'(op));
        end

        // R11: chain 0 disables issue
        set_chain(5'd0);
        scan_ir(C_INTEST, cap, 1'b0);
        c0 = issue_cnt;
        scan_dr(8, 64'hB6, d, 1'b1);
        idle_wait(3);
        chk("R11", "no issue on chain 0 intest", 64'(issue_cnt - c0), 64'd0);
        chk("R11", "chain 0 bypass data", d & 64'hFF, 64'h6C);
        scan_ir(C_EXTEST, cap, 1'b1);
        idle_wait(3);
        chk("R11", "no issue on chain 0 extest", 64'(issue_cnt - c0), 64'd0);

        // R8 R9 R12: host to core
        set_chain(5'd5);
        scan_ir(C_EXTEST, cap, 1'b0);
        h2c_auto = 0;
        w = $urandom;
        scan_dr(34, 64'(w), d, 1'b0);
        chk("R8", "ready when empty", 64'(d[32]), 64'd1);
        chk("R8", "nretry bit", 64'(d[33]), 64'd1);
        chk("R8", "extest data capture", d & 64'hFFFF_FFFF, 64'd0);
        #1;
        chk("R8", "h2c_valid set", 64'(h2c_valid), 64'd1);
        chk("R8", "h2c_data", 64'(h2c_data), 64'(w));
        w2 = ~w;
        scan_dr(34, 64'(w2), d, 1'b0);
        chk("R9", "ready when full", 64'(d[32]), 64'd0);
        #1;
        chk("R9", "word kept", 64'(h2c_data), 64'(w));
        t0 = h2c_taken;
        h2c_auto = 1;
        scan_ir(C_EXTEST, cap, 1'b0);
        #1;
        chk("R12", "valid cleared by ack", 64'(h2c_valid), 64'd0);
        chk("R12", "core took word", 64'(h2c_last), 64'(w));
        for (int k = 0; k < 16; k++) begin
            w = $urandom;
            scan_dr(34, 64'(w), d, 1'b0);
            chk("R8", "random ready", 64'(d[32]), 64'd1);
            #1;
            chk("R8", "random h2c word", 64'(h2c_data), 64'(w));
        end
        scan_ir(C_INTEST, cap, 1'b0);
        chk("R12", "all words taken", 64'(h2c_taken - t0), 64'd17);

        // R10: core to host
        for (int k = 0; k < 12; k++) begin
            t0 = c2h_taken;
            c2h_data = $urandom;
            c2h_full = 1'b1;
            scan_dr(34, 64'd0, d, 1'b0);
            chk("R10", "c2h data", d & 64'hFFFF_FFFF, 64'(c2h_data));
            chk("R10", "ready when full", 64'(d[32]), 64'd1);
            chk("R10", "ack count", 64'(c2h_taken - t0), 64'd1);
        end
        t0 = c2h_taken;
        c2h_full = 1'b0;
        scan_dr(34, 64'd0, d, 1'b0);
        chk("R10", "ready when empty", 64'(d[32]), 64'd0);
        chk("R10", "no ack when empty", 64'(c2h_taken - t0), 64'd0);

        // R1: five TMS-high cycles reset IR and select
        for (int k = 0; k < 5; k++) tck(1'b1, 1'b0, o);
        tck(1'b0, 1'b0, o);
        at_sel = 0;
        scan_ir(C_INTEST, cap, 1'b0);
        probe(len, d);
        chk("R1", "select cleared by tms reset", 64'(len), 64'd1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule